// File: doc/BRIEF.md
# Cache Line Maintenance Sequencer

This block is the control engine for line-level maintenance in a small direct-mapped write-back data cache. It accepts one command at a time. The command is a 5-bit hint code plus a byte address. The block checks the tag of the indexed line and, depending on the hint, carries out one of these actions:

- **Write back and invalidate:** flush the line and drop it.
- **Write back and keep:** clean the line and keep it valid.
- **Lock or unlock:** set or clear the line's lock bit.
- **Prepare for store:** claim the line for a full overwrite. On a miss the line is filled with zeros, with no read from memory.

A dirty line that must leave the cache goes out through a single-beat request/acknowledge write port that carries a whole line. The block raises `done` for one cycle with a result code when the command finishes.

The tag, state bits and line data live in small register arrays inside the block. With the defaults the geometry is 16 lines of four 32-bit words. Address bits [3:0] select a byte in the line and are ignored. Bits [7:4] are the line index. Bits [31:8] are the tag.

Top module: `cline_maint_seq`

## Requirements
- R1: `cmd_ready` is high only when the block is idle. A command is taken on a cycle with `cmd_valid` and `cmd_ready` both high, and `cmd_ready` is low on the following cycle.
- R2: Hint 25 selects write-back-invalidate, 27 write-back-keep, 28 lock, 29 unlock and 30 prepare-for-store. Any other hint does nothing and completes with result 0 (none), with `done` 2 cycles after acceptance.
- R3: A write-back-invalidate that misses completes with result 1 (miss) after 2 cycles and issues no memory request.
- R4: A write-back-invalidate that hits a dirty, unlocked line issues one request. The request carries the line address (tag and index, offset zero) and the line data. `done` comes only after `mem_ack`, with result 5 (written back), and the line is invalid afterwards.
- R5: A write-back-invalidate that hits a clean, unlocked line invalidates it without memory traffic, with result 4 after 3 cycles.
- R6: A prepare-for-store that hits an unlocked line changes nothing, with result 3 (hit) after 2 cycles.
- R7: A prepare-for-store that misses with an invalid or clean victim writes zeros to all four words and marks the line valid and dirty with the new tag. It makes no memory request and finishes with result 6 after 7 cycles.
- R8: A prepare-for-store that misses with a valid dirty victim first writes the victim back at the victim's own line address, then zero-fills and allocates, with result 7.
- R9: If the indexed target line is locked, write-back-invalidate, write-back-keep and prepare-for-store do nothing, with result 2 (locked). Lock and unlock set or clear the bit on a hit, with result 3 after 3 cycles, and report result 1 on a miss.
- R10: Write-back-keep on a dirty hit writes the line back and leaves it valid and clean, with result 5. On a clean hit it finishes with result 3.
- R11: `done` and `mem_req` are single-cycle pulses, and the block is idle again the cycle after `done`.
- R12: Lines at different indices are independent, and the byte-offset bits of the address never affect the outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command will be taken |
| cmd_hint | input | 5 | Operation hint code |
| cmd_addr | input | ADDR_W | Byte address of target |
| done | output | 1 | Command finished (one cycle) |
| done_status | output | 3 | Result code, valid with done |
| mem_req | output | 1 | Line write-back request (one cycle) |
| mem_addr | output | ADDR_W | Line address of the write-back |
| mem_data | output | WORDS*WORD_W | Line contents being written back |
| mem_ack | input | 1 | Write-back accepted by memory |

## Verification
The tests drive all five operations against lines in each relevant state: invalid, valid-clean, valid-dirty and locked. This separates each branch of the lookup decision by its result code and completion latency.

Aliasing addresses share an index but differ in tag. They force a dirty victim, and that separates the victim's write-back address from the incoming tag. A follow-up invalidate then proves the eviction happened. Follow-up commands on the same line expose state that is otherwise hidden: a miss after an invalidate shows the line was dropped, a zero-data write-back after an allocation shows the zero fill, and a second keep showing a hit shows the dirty bit was cleared.

A delayed acknowledge separates an ordering that waits for the write-back from one that updates the line early.

// File: rtl/clm_pkg.sv
`timescale 1ns/1ps
package clm_pkg;

    localparam logic [4:0] HINT_WBINV  = 5'd25;
    localparam logic [4:0] HINT_CLEAN  = 5'd27;
    localparam logic [4:0] HINT_LOCK   = 5'd28;
    localparam logic [4:0] HINT_UNLOCK = 5'd29;
    localparam logic [4:0] HINT_ZALLOC = 5'd30;

    typedef enum logic [2:0] {
        OP_NOP, OP_WBINV, OP_CLEAN, OP_LOCK, OP_UNLOCK, OP_ZALLOC
    } clm_op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_LOOKUP, S_WB_REQ, S_WB_WAIT, S_ZERO_FILL, S_UPDATE, S_DONE
    } clm_state_e;

    typedef enum logic [2:0] {
        ST_NOP      = 3'd0,
        ST_MISS     = 3'd1,
        ST_LOCKED   = 3'd2,
        ST_HIT      = 3'd3,
        ST_INVAL    = 3'd4,
        ST_WB       = 3'd5,
        ST_ALLOC    = 3'd6,
        ST_WB_ALLOC = 3'd7
    } clm_status_e;

    typedef struct packed {
        logic valid;
        logic dirty;
        logic lock;
    } clm_flags_t;

    function automatic clm_op_e hint_to_op(input logic [4:0] hint);
        case (hint)
            HINT_WBINV:  return OP_WBINV;
            HINT_CLEAN:  return OP_CLEAN;
            HINT_LOCK:   return OP_LOCK;
            HINT_UNLOCK: return OP_UNLOCK;
            HINT_ZALLOC: return OP_ZALLOC;
            default:     return OP_NOP;
        endcase
    endfunction

endpackage

// File: rtl/clm_tag_store.sv
`timescale 1ns/1ps
module clm_tag_store
    import clm_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int TAG_W = 24,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] rd_tag,
    output clm_flags_t       rd_flags,
    input  logic             we,
    input  logic [TAG_W-1:0] wr_tag,
    input  clm_flags_t       wr_flags
);
    logic [TAG_W-1:0] tag_q  [SETS];
    clm_flags_t       flag_q [SETS];

    for (genvar g = 0; g < SETS; g++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[g] <= '0;
            end else if (we && idx == IDX_W'(g)) begin
                flag_q[g] <= wr_flags;
            end
        end
        always_ff @(posedge clk) begin
            if (we && idx == IDX_W'(g)) begin
                tag_q[g] <= wr_tag;
            end
        end
    end

    assign rd_tag   = tag_q[idx];
    assign rd_flags = flag_q[idx];
endmodule

// File: rtl/clm_line_store.sv
`timescale 1ns/1ps
module clm_line_store #(
    parameter int SETS   = 16,
    parameter int WORDS  = 4,
    parameter int WORD_W = 32,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int LINE_W = WORDS * WORD_W
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              we,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data
);
    logic [WORD_W-1:0] data_q [SETS][WORDS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (we && idx == IDX_W'(s) && wr_word == WSEL_W'(w)) begin
                    data_q[s][w] <= wr_data;
                end
            end
        end
    end

    always_comb begin
        for (int w = 0; w < WORDS; w++) begin
            rd_line[w*WORD_W +: WORD_W] = data_q[idx][w];
        end
    end
endmodule

// File: rtl/clm_ctrl.sv
`timescale 1ns/1ps
module clm_ctrl
    import clm_pkg::*;
#(
    parameter int WORDS = 4,
    parameter int IDX_W = 4,
    parameter int TAG_W = 24,
    localparam int WSEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [4:0]        cmd_hint,
    input  logic [TAG_W-1:0]  cmd_tag,
    input  logic [IDX_W-1:0]  cmd_idx,
    output logic              cmd_ready,
    output logic              done,
    output clm_status_e       status,
    input  logic [TAG_W-1:0]  rd_tag,
    input  clm_flags_t        rd_flags,
    output logic [IDX_W-1:0]  idx,
    output logic              tag_we,
    output logic [TAG_W-1:0]  tag_wdata,
    output clm_flags_t        flags_wdata,
    output logic              fill_we,
    output logic [WSEL_W-1:0] fill_word,
    output logic              mem_req,
    input  logic              mem_ack,
    output logic [TAG_W-1:0]  wb_tag
);
    clm_state_e        state_q, state_d;
    clm_op_e           op_q;
    clm_status_e       status_q, status_d;
    logic [TAG_W-1:0]  tag_q, vtag_q, vtag_d;
    logic [IDX_W-1:0]  idx_q;
    logic [WSEL_W-1:0] word_q, word_d;
    logic              hit;

    assign hit = rd_flags.valid && (rd_tag == tag_q);

    always_comb begin
        state_d     = state_q;
        status_d    = status_q;
        vtag_d      = vtag_q;
        word_d      = word_q;
        tag_we      = 1'b0;
        tag_wdata   = tag_q;
        flags_wdata = '0;
        fill_we     = 1'b0;
        mem_req     = 1'b0;
        case (state_q)
            S_IDLE: if (cmd_valid) state_d = S_LOOKUP;
            S_LOOKUP: begin
                vtag_d = rd_tag;
                word_d = '0;
                state_d = S_DONE;
                case (op_q)
                    OP_WBINV, OP_CLEAN: begin
                        if (!hit)                status_d = ST_MISS;
                        else if (rd_flags.lock)  status_d = ST_LOCKED;
                        else if (rd_flags.dirty) begin
                            status_d = ST_WB;
                            state_d  = S_WB_REQ;
                        end else if (op_q == OP_WBINV) begin
                            status_d = ST_INVAL;
                            state_d  = S_UPDATE;
                        end else                 status_d = ST_HIT;
                    end
                    OP_LOCK, OP_UNLOCK: begin
                        if (!hit) status_d = ST_MISS;
                        else begin
                            status_d = ST_HIT;
                            state_d  = S_UPDATE;
                        end
                    end
                    OP_ZALLOC: begin
                        if (rd_flags.valid && rd_flags.lock) status_d = ST_LOCKED;
                        else if (hit)                        status_d = ST_HIT;
                        else if (rd_flags.valid && rd_flags.dirty) begin
                            status_d = ST_WB_ALLOC;
                            state_d  = S_WB_REQ;
                        end else begin
                            status_d = ST_ALLOC;
                            state_d  = S_ZERO_FILL;
                        end
                    end
                    default: status_d = ST_NOP;
                endcase
            end
            S_WB_REQ: begin
                mem_req = 1'b1;
                state_d = S_WB_WAIT;
            end
            S_WB_WAIT: begin
                if (mem_ack) state_d = (op_q == OP_ZALLOC) ? S_ZERO_FILL : S_UPDATE;
            end
            S_ZERO_FILL: begin
                fill_we = 1'b1;
                if (word_q == WSEL_W'(WORDS - 1)) state_d = S_UPDATE;
                else word_d = word_q + 1'b1;
            end
            S_UPDATE: begin
                tag_we  = 1'b1;
                state_d = S_DONE;
                case (op_q)
                    OP_CLEAN:  flags_wdata = '{valid: 1'b1, dirty: 1'b0, lock: 1'b0};
                    OP_ZALLOC: flags_wdata = '{valid: 1'b1, dirty: 1'b1, lock: 1'b0};
                    OP_LOCK, OP_UNLOCK: begin
                        flags_wdata      = rd_flags;
                        flags_wdata.lock = (op_q == OP_LOCK);
                    end
                    default:   flags_wdata = '0;
                endcase
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            status_q <= ST_NOP;
            op_q     <= OP_NOP;
            tag_q    <= '0;
            idx_q    <= '0;
            vtag_q   <= '0;
            word_q   <= '0;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
            vtag_q   <= vtag_d;
            word_q   <= word_d;
            if (state_q == S_IDLE && cmd_valid) begin
                op_q  <= hint_to_op(cmd_hint);
                tag_q <= cmd_tag;
                idx_q <= cmd_idx;
            end
        end
    end

    assign cmd_ready = (state_q == S_IDLE);
    assign done      = (state_q == S_DONE);
    assign status    = status_q;
    assign idx       = idx_q;
    assign fill_word = word_q;
    assign wb_tag    = vtag_q;
endmodule

// File: rtl/cline_maint_seq.sv
`timescale 1ns/1ps
module cline_maint_seq
    import clm_pkg::*;
#(
    parameter int WORDS  = 4,
    parameter int WORD_W = 32,
    parameter int SETS   = 16,
    parameter int ADDR_W = 32,
    localparam int LINE_W = WORDS * WORD_W,
    localparam int OFF_W  = $clog2(LINE_W / 8),
    localparam int IDX_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
    localparam int WSEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [4:0]        cmd_hint,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              done,
    output logic [2:0]        done_status,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_data,
    input  logic              mem_ack
);
    logic [TAG_W-1:0]  rd_tag, tag_wdata, wb_tag;
    clm_flags_t        rd_flags, flags_wdata;
    logic [IDX_W-1:0]  idx;
    logic              tag_we, fill_we;
    logic [WSEL_W-1:0] fill_word;
    clm_status_e       status;
    logic              unused_offset;

    assign unused_offset = ^cmd_addr[OFF_W-1:0];

    clm_ctrl #(.WORDS(WORDS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_hint(cmd_hint),
        .cmd_tag(cmd_addr[ADDR_W-1 -: TAG_W]),
        .cmd_idx(cmd_addr[OFF_W +: IDX_W]),
        .cmd_ready(cmd_ready), .done(done), .status(status),
        .rd_tag(rd_tag), .rd_flags(rd_flags), .idx(idx),
        .tag_we(tag_we), .tag_wdata(tag_wdata), .flags_wdata(flags_wdata),
        .fill_we(fill_we), .fill_word(fill_word),
        .mem_req(mem_req), .mem_ack(mem_ack), .wb_tag(wb_tag)
    );

    clm_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst(rst), .idx(idx),
        .rd_tag(rd_tag), .rd_flags(rd_flags),
        .we(tag_we), .wr_tag(tag_wdata), .wr_flags(flags_wdata)
    );

    clm_line_store #(.SETS(SETS), .WORDS(WORDS), .WORD_W(WORD_W)) u_lines (
        .clk(clk), .idx(idx), .rd_line(mem_data),
        .we(fill_we), .wr_word(fill_word), .wr_data('0)
    );

    assign done_status = status;
    assign mem_addr    = {wb_tag, idx, {OFF_W{1'b0}}};
endmodule

// File: rtl/clm_checker.sv
`timescale 1ns/1ps
module clm_checker
    import clm_pkg::*;
#(
    parameter int WORDS = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic       done,
    input logic [2:0] done_status,
    input logic       mem_req,
    input logic       mem_ack,
    input logic       fill_we
);
    logic                       wb_pend, saw_req;
    logic [$clog2(WORDS)+1:0]   fills;

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_pend <= 1'b0;
            saw_req <= 1'b0;
            fills   <= '0;
        end else begin
            if (mem_req)      wb_pend <= 1'b1;
            else if (mem_ack) wb_pend <= 1'b0;
            if (cmd_valid && cmd_ready) begin
                saw_req <= 1'b0;
                fills   <= '0;
            end else begin
                if (mem_req) saw_req <= 1'b1;
                if (fill_we) fills <= fills + 1'b1;
            end
        end
    end

    p_ready_drop_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready |=> !cmd_ready);

    p_done_after_ack_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> !wb_pend);

    p_no_traffic_r3: assert property (@(posedge clk) disable iff (rst)
        done && (done_status == ST_MISS || done_status == ST_NOP ||
                 done_status == ST_LOCKED || done_status == ST_HIT ||
                 done_status == ST_INVAL || done_status == ST_ALLOC) |-> !saw_req);

    p_victim_wb_r8: assert property (@(posedge clk) disable iff (rst)
        done && done_status == ST_WB_ALLOC |-> saw_req);

    p_fill_words_r7: assert property (@(posedge clk) disable iff (rst)
        done && (done_status == ST_ALLOC || done_status == ST_WB_ALLOC)
        |-> int'(fills) == WORDS);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && cmd_ready);

    p_req_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);
endmodule

bind cline_maint_seq clm_checker #(.WORDS(WORDS)) u_clm_checker (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .done(done), .done_status(done_status), .mem_req(mem_req),
    .mem_ack(mem_ack), .fill_we(fill_we)
);

// File: tb/test_cline_maint_seq.sv
`timescale 1ns/1ps
module test_cline_maint_seq;
    import clm_pkg::*;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [4:0]   cmd_hint = '0;
    logic [31:0]  cmd_addr = '0;
    logic         done;
    logic [2:0]   done_status;
    logic         mem_req;
    logic [31:0]  mem_addr;
    logic [127:0] mem_data;
    logic         mem_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    bit wb_pend = 1'b0;
    bit finished = 1'b0;

    logic [2:0]  q_st[$];
    string       q_req[$];
    logic [31:0] q_wb[$];
    string       q_wbreq[$];

    always #2 clk = ~clk;

    cline_maint_seq i_cline_maint_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_hint(cmd_hint), .cmd_addr(cmd_addr), .done(done),
        .done_status(done_status), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_ack(mem_ack)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected results as the design completes commands
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (done) begin
                if (q_st.size() == 0) begin
                    chk(1'b0, "R11 unexpected done", done_status, 0);
                end else begin
                    automatic logic [2:0] st = q_st.pop_front();
                    automatic string r = q_req.pop_front();
                    chk(done_status == st, r, done_status, st);
                end
                chk(!wb_pend, "R4 done before write-back ack", wb_pend, 0);
            end
        end
    end

    // Memory responder: checks each write-back, acknowledges after a delay
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mem_req) begin
                wb_pend = 1'b1;
                if (q_wb.size() == 0) begin
                    chk(1'b0, "R3 unexpected write-back", mem_addr, 0);
                end else begin
                    automatic logic [31:0] ea = q_wb.pop_front();
                    automatic string r = q_wbreq.pop_front();
                    chk(mem_addr == ea, r, mem_addr, ea);
                    chk(mem_data == '0, "R7 written-back line is zero-filled", |mem_data, 0);
                end
                repeat (3) @(posedge clk);
                #1 mem_ack = 1'b1;
                @(posedge clk);
                #1 mem_ack = 1'b0;
                wb_pend = 1'b0;
            end
        end
    end

    task automatic expect_wb(input logic [31:0] a, input string req);
        q_wb.push_back(a);
        q_wbreq.push_back(req);
    endtask

    // Driver: pushes the expected result, issues one command, checks latency
    task automatic run(input logic [4:0] h, input logic [31:0] a,
                       input logic [2:0] st, input int lat, input string req);
        int n;
        q_st.push_back(st);
        q_req.push_back(req);
        cmd_hint  = h;
        cmd_addr  = a;
        cmd_valid = 1'b1;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        chk(!cmd_ready, "R1 ready low after accept", cmd_ready, 0);
        n = 1;
        while (!done && n < 1000) begin
            @(posedge clk);
            #1;
            n++;
        end
        if (lat != 0) chk(n == lat, {req, " latency"}, n, lat);
        @(posedge clk);
        #1;
        chk(cmd_ready && !done, "R11 idle after done pulse", {cmd_ready, done}, 2'b10);
    endtask

    localparam logic [31:0] A  = 32'h1000_0040;
    localparam logic [31:0] B  = 32'h2000_0040;
    localparam logic [31:0] C  = 32'h1000_0050;
    localparam logic [31:0] D  = 32'h3000_0050;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
        chk(done == 1'b0, "R11 done low after reset", done, 0);
        chk(mem_req == 1'b0, "R11 no request after reset", mem_req, 0);

        run(HINT_WBINV, A, ST_MISS, 2, "R3 invalidate miss");
        run(5'd4, A, ST_NOP, 2, "R2 unassigned hint 4");
        run(5'd24, A, ST_NOP, 2, "R2 unassigned hint 24");
        run(HINT_ZALLOC, A, ST_ALLOC, 7, "R7 allocate into invalid line");
        run(HINT_ZALLOC, A + 32'hC, ST_HIT, 2, "R6 prepare hit, R12 offset ignored");
        run(HINT_WBINV, C, ST_MISS, 2, "R12 other index unaffected");

        expect_wb(A, "R8 victim write-back address");
        run(HINT_ZALLOC, B, ST_WB_ALLOC, 0, "R8 allocate over dirty victim");
        run(HINT_WBINV, A, ST_MISS, 2, "R8 victim evicted");
        expect_wb(B, "R4 write-back line address");
        run(HINT_WBINV, B + 32'h4, ST_WB, 0, "R4 dirty invalidate");
        run(HINT_WBINV, B, ST_MISS, 2, "R4 line invalid after write-back");

        run(HINT_ZALLOC, A, ST_ALLOC, 7, "R7 allocate again");
        expect_wb(A, "R10 keep write-back address");
        run(HINT_CLEAN, A, ST_WB, 0, "R10 dirty keep");
        run(HINT_CLEAN, A, ST_HIT, 2, "R10 line now clean");
        run(HINT_WBINV, A, ST_INVAL, 3, "R5 clean invalidate");
        run(HINT_WBINV, A, ST_MISS, 2, "R5 line gone");

        run(HINT_ZALLOC, C, ST_ALLOC, 7, "R12 allocate index 5");
        run(HINT_LOCK, C, ST_HIT, 3, "R9 lock hit");
        run(HINT_WBINV, C, ST_LOCKED, 2, "R9 locked invalidate");
        run(HINT_CLEAN, C, ST_LOCKED, 2, "R9 locked keep");
        run(HINT_ZALLOC, D, ST_LOCKED, 2, "R9 locked victim");
        run(HINT_ZALLOC, C, ST_LOCKED, 2, "R9 locked prepare hit");
        run(HINT_LOCK, B, ST_MISS, 2, "R9 lock miss");
        run(HINT_UNLOCK, C, ST_HIT, 3, "R9 unlock hit");
        expect_wb(C, "R9 write-back after unlock");
        run(HINT_WBINV, C, ST_WB, 0, "R9 invalidate after unlock");

        repeat (8) @(posedge clk);
        #1;
        chk(q_wb.size() == 0, "R4 all expected write-backs seen", q_wb.size(), 0);
        chk(q_st.size() == 0, "R11 all expected results seen", q_st.size(), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule